// File: doc/BRIEF.md
# Wait-Instruction Trap Router

This unit decides, for a single wait-for-event or wait-for-interrupt instruction, whether execution must be diverted into an exception and which privilege level takes it. The issuing pipeline raises a one-cycle request together with the instruction kind, the current privilege level (0 to 3), the security state and a description of the system: which of levels 2 and 3 exist, which levels run in the 64-bit execution state, and the six trap-control bits held by the level-1 system control, level-2 hypervisor configuration and level-3 secure configuration registers.

Three candidate targets are examined in a fixed order, lowest level first. The level-1 candidate uses "do not trap" bits, so it traps when its bit is clear. The level-2 and level-3 candidates trap when their bit is set. Each candidate is considered only when the current level, the security state and the implemented levels allow it. The first candidate that traps wins. The unit then returns, one cycle after the request, a registered response: the trap flag, the target level, a fault class, a six-bit exception class code and the syndrome value.

Top module: `wfx_trap_route`

## Requirements
- R1: A synchronous active-high reset clears the valid and trap outputs, and all the response fields, on the next clock edge.
- R2: The response appears exactly one cycle after the request strobe, and `rsp_valid` is high for that one cycle. In a cycle after a clock edge with no strobe, `rsp_valid` and `rsp_trap` are low and every response field is zero.
- R3: The level-1 candidate is examined only when the current level is 0. It traps a wait-for-event when `sys_nt_evt` is 0, and a wait-for-interrupt when `sys_nt_int` is 0.
- R4: If level 1 does not trap, the level-2 candidate is examined only when `has_lvl2` is 1, `sec_state` is 0 and the current level is 0 or 1. It traps on `hyp_t_evt` = 1 (event) or `hyp_t_int` = 1 (interrupt).
- R5: If neither earlier candidate traps, the level-3 candidate is examined when `has_lvl3` is 1 and the current level is not 3. It traps on `mon_t_evt` = 1 (event) or `mon_t_int` = 1 (interrupt).
- R6: When several candidates would trap, the lowest target level is reported (1 before 2 before 3). `rsp_lvl` carries the target level as a 2-bit number.
- R7: On a trap, `rsp_syn` is 0x1E00001 for a wait-for-event and 0x1E00000 for a wait-for-interrupt.
- R8: For a level-1 target, `rsp_fault` is 1 (undefined instruction) when `lvl_wide[1]` is 0 (32-bit state) and 2 (supervisor trap) when `lvl_wide[1]` is 1 (64-bit state). Bit n of `lvl_wide` belongs to level n.
- R9: A level-2 target gives `rsp_fault` = 3 (hypervisor trap) and a level-3 target gives `rsp_fault` = 4 (secure monitor trap), whatever `lvl_wide[2]` and `lvl_wide[3]` hold.
- R10: On a trap, `rsp_ec` is 0x01. Without a trap, `rsp_lvl`, `rsp_fault`, `rsp_ec` and `rsp_syn` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_is_evt | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| cur_lvl | input | 2 | Current privilege level |
| sec_state | input | 1 | 1 = secure state |
| has_lvl2 | input | 1 | Level 2 is implemented |
| has_lvl3 | input | 1 | Level 3 is implemented |
| lvl_wide | input | 3 | Bit n (n = 1..3): level n runs in the 64-bit state |
| sys_nt_evt | input | 1 | Level-1 "do not trap" bit for event waits |
| sys_nt_int | input | 1 | Level-1 "do not trap" bit for interrupt waits |
| hyp_t_evt | input | 1 | Level-2 trap bit for event waits |
| hyp_t_int | input | 1 | Level-2 trap bit for interrupt waits |
| mon_t_evt | input | 1 | Level-3 trap bit for event waits |
| mon_t_int | input | 1 | Level-3 trap bit for interrupt waits |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_trap | output | 1 | The instruction traps |
| rsp_lvl | output | 2 | Target level (0 when no trap) |
| rsp_fault | output | 3 | Fault class code |
| rsp_ec | output | 6 | Exception class code |
| rsp_syn | output | 25 | Syndrome value |

## Verification
The hardest cases to reach are the ones where an inner candidate would trap but is masked, so that a later level takes the trap or none does: a set level-2 bit in secure state, a level-1 clear bit while running at level 1, a level-3 bit while already at level 3. Directed scenarios set each of these up on purpose, and a final sweep drives every combination of kind, level, security state, implemented levels, widths and the six control bits as back-to-back strobes and compares each response with a model written from the requirements.

// File: rtl/wfx_trap_pkg.sv
package wfx_trap_pkg;
  localparam int LVL_W = 2;
  localparam int FLT_W = 3;
  localparam int EC_W  = 6;
  localparam int SYN_W = 25;
  localparam int NUM_TGT = 3;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE  = 3'd0,
    FLT_UNDEF = 3'd1,
    FLT_SVC   = 3'd2,
    FLT_HYP   = 3'd3,
    FLT_MON   = 3'd4
  } fault_e;

  localparam logic [EC_W-1:0]  EC_WAIT_TRAP = 6'h01;
  localparam logic [SYN_W-1:0] SYN_BASE     = 25'h1E00000;
endpackage

// File: rtl/wfx_lvl_check.sv
module wfx_lvl_check #(
  parameter int LEVEL = 1
) (
  input  logic is_evt,
  input  logic ctl_evt,
  input  logic ctl_int,
  input  logic eligible,
  output logic hit
);
  logic raw;

  generate
    if (LEVEL == 1) begin : g_clear_traps
      // level 1 holds "do not trap" bits
      assign raw = is_evt ? ~ctl_evt : ~ctl_int;
    end else begin : g_set_traps
      assign raw = is_evt ? ctl_evt : ctl_int;
    end
  endgenerate

  assign hit = eligible & raw;
endmodule

// File: rtl/wfx_route_sel.sv
module wfx_route_sel
  import wfx_trap_pkg::*;
(
  input  logic [NUM_TGT:1]  hit,
  input  logic [NUM_TGT:1]  lvl_wide,
  output logic              trap,
  output logic [LVL_W-1:0]  tgt_lvl,
  output logic [FLT_W-1:0]  fault
);
  logic [NUM_TGT:0] wide_ext;
  fault_e           flt;

  assign wide_ext = {lvl_wide, 1'b0};

  always_comb begin
    tgt_lvl = '0;
    for (int i = NUM_TGT; i >= 1; i--) begin
      if (hit[i]) tgt_lvl = LVL_W'(i);
    end
  end

  assign trap = |hit;

  always_comb begin
    case (tgt_lvl)
      2'd1:    flt = wide_ext[tgt_lvl] ? FLT_SVC : FLT_UNDEF;
      2'd2:    flt = FLT_HYP;
      2'd3:    flt = FLT_MON;
      default: flt = FLT_NONE;
    endcase
  end

  assign fault = flt;
endmodule

// File: rtl/wfx_trap_route.sv
module wfx_trap_route
  import wfx_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_evt,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic              sec_state,
  input  logic              has_lvl2,
  input  logic              has_lvl3,
  input  logic [3:1]        lvl_wide,
  input  logic              sys_nt_evt,
  input  logic              sys_nt_int,
  input  logic              hyp_t_evt,
  input  logic              hyp_t_int,
  input  logic              mon_t_evt,
  input  logic              mon_t_int,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [LVL_W-1:0]  rsp_lvl,
  output logic [FLT_W-1:0]  rsp_fault,
  output logic [EC_W-1:0]   rsp_ec,
  output logic [SYN_W-1:0]  rsp_syn
);
  logic [NUM_TGT:1] elig;
  logic [NUM_TGT:1] ctl_e;
  logic [NUM_TGT:1] ctl_i;
  logic [NUM_TGT:1] hit;
  logic             trap_c;
  logic [LVL_W-1:0] lvl_c;
  logic [FLT_W-1:0] flt_c;

  // candidate gating by current level, security state and presence
  assign elig[1] = (cur_lvl == 2'd0);
  assign elig[2] = has_lvl2 & ~sec_state & (cur_lvl <= 2'd1);
  assign elig[3] = has_lvl3 & (cur_lvl != 2'd3);

  assign ctl_e = {mon_t_evt, hyp_t_evt, sys_nt_evt};
  assign ctl_i = {mon_t_int, hyp_t_int, sys_nt_int};

  generate
    for (genvar g = 1; g <= NUM_TGT; g++) begin : g_tgt
      wfx_lvl_check #(.LEVEL(g)) u_chk (
        .is_evt   (req_is_evt),
        .ctl_evt  (ctl_e[g]),
        .ctl_int  (ctl_i[g]),
        .eligible (elig[g]),
        .hit      (hit[g])
      );
    end
  endgenerate

  wfx_route_sel u_sel (
    .hit      (hit),
    .lvl_wide (lvl_wide),
    .trap     (trap_c),
    .tgt_lvl  (lvl_c),
    .fault    (flt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_lvl   <= '0;
      rsp_fault <= '0;
      rsp_ec    <= '0;
      rsp_syn   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && trap_c) begin
        rsp_trap  <= 1'b1;
        rsp_lvl   <= lvl_c;
        rsp_fault <= flt_c;
        rsp_ec    <= EC_WAIT_TRAP;
        rsp_syn   <= SYN_BASE | SYN_W'(req_is_evt);
      end else begin
        rsp_trap  <= 1'b0;
        rsp_lvl   <= '0;
        rsp_fault <= '0;
        rsp_ec    <= '0;
        rsp_syn   <= '0;
      end
    end
  end
endmodule

// File: rtl/wfx_trap_route_chk.sv
module wfx_trap_route_chk
  import wfx_trap_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_is_evt,
  input logic [LVL_W-1:0]  cur_lvl,
  input logic              sec_state,
  input logic              has_lvl2,
  input logic              has_lvl3,
  input logic              rsp_valid,
  input logic              rsp_trap,
  input logic [LVL_W-1:0]  rsp_lvl,
  input logic [FLT_W-1:0]  rsp_fault,
  input logic [EC_W-1:0]   rsp_ec,
  input logic [SYN_W-1:0]  rsp_syn
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_trap));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_trap && rsp_syn == '0));

  // R3
  lvl1_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_lvl == 2'd1) |-> ($past(cur_lvl) == 2'd0));

  // R4
  lvl2_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_lvl == 2'd2) |->
      $past(has_lvl2 && !sec_state && cur_lvl <= 2'd1));

  // R5
  lvl3_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_lvl == 2'd3) |-> $past(has_lvl3 && cur_lvl != 2'd3));

  // R7
  syndrome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_syn[SYN_W-1:1] == SYN_BASE[SYN_W-1:1] &&
                  rsp_syn[0] == $past(req_is_evt)));

  // R9
  hyp_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_lvl == 2'd2) |-> (rsp_fault == 3'd3));

  // R9
  mon_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap && rsp_lvl == 2'd3) |-> (rsp_fault == 3'd4));

  // R10
  trap_fields_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_ec == 6'h01 && rsp_lvl != 2'd0 && rsp_valid));

  // R10
  notrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_trap |-> (rsp_lvl == '0 && rsp_fault == '0 &&
                   rsp_ec == '0 && rsp_syn == '0));
endmodule

bind wfx_trap_route wfx_trap_route_chk u_route_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_is_evt (req_is_evt),
  .cur_lvl    (cur_lvl),
  .sec_state  (sec_state),
  .has_lvl2   (has_lvl2),
  .has_lvl3   (has_lvl3),
  .rsp_valid  (rsp_valid),
  .rsp_trap   (rsp_trap),
  .rsp_lvl    (rsp_lvl),
  .rsp_fault  (rsp_fault),
  .rsp_ec     (rsp_ec),
  .rsp_syn    (rsp_syn)
);

// File: tb/wfx_trap_route_bench.sv
module wfx_trap_route_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_evt = 1'b0;
  logic [1:0]  cur_lvl = 2'd0;
  logic        sec_state = 1'b0;
  logic        has_lvl2 = 1'b0;
  logic        has_lvl3 = 1'b0;
  logic [3:1]  lvl_wide = 3'b000;
  logic        sys_nt_evt = 1'b1, sys_nt_int = 1'b1;
  logic        hyp_t_evt = 1'b0, hyp_t_int = 1'b0;
  logic        mon_t_evt = 1'b0, mon_t_int = 1'b0;
  logic        rsp_valid, rsp_trap;
  logic [1:0]  rsp_lvl;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_ec;
  logic [24:0] rsp_syn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wfx_trap_route u_wfx_trap_route (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_evt(req_is_evt),
    .cur_lvl(cur_lvl), .sec_state(sec_state), .has_lvl2(has_lvl2),
    .has_lvl3(has_lvl3), .lvl_wide(lvl_wide),
    .sys_nt_evt(sys_nt_evt), .sys_nt_int(sys_nt_int),
    .hyp_t_evt(hyp_t_evt), .hyp_t_int(hyp_t_int),
    .mon_t_evt(mon_t_evt), .mon_t_int(mon_t_int),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_lvl(rsp_lvl),
    .rsp_fault(rsp_fault), .rsp_ec(rsp_ec), .rsp_syn(rsp_syn)
  );

  // response vector: {valid, trap, lvl[2], fault[3], ec[6], syn[25]}
  function automatic logic [37:0] model(
    input logic evt, input logic [1:0] cur, input logic sec,
    input logic h2, input logic h3, input logic [3:1] wide,
    input logic [5:0] ctl);  // {mon_int, mon_evt, hyp_int, hyp_evt, nt_int, nt_evt}
    logic [1:0] lvl;
    logic [2:0] flt;
    lvl = 2'd0;
    if (cur == 2'd0 && !(evt ? ctl[0] : ctl[1]))                  lvl = 2'd1; // R3
    else if (h2 && !sec && cur <= 2'd1 && (evt ? ctl[2] : ctl[3])) lvl = 2'd2; // R4
    else if (h3 && cur != 2'd3 && (evt ? ctl[4] : ctl[5]))         lvl = 2'd3; // R5
    case (lvl)
      2'd1:    flt = wide[1] ? 3'd2 : 3'd1;   // R8
      2'd2:    flt = 3'd3;                    // R9
      2'd3:    flt = 3'd4;
      default: flt = 3'd0;
    endcase
    if (lvl == 2'd0) return {1'b1, 37'd0};                      // R10
    return {1'b1, 1'b1, lvl, flt, 6'h01, 25'h1E00000 | 25'(evt)}; // R7
  endfunction

  function automatic logic [37:0] observed();
    return {rsp_valid, rsp_trap, rsp_lvl, rsp_fault, rsp_ec, rsp_syn};
  endfunction

  task automatic chk(input string tag, input logic [37:0] got, input logic [37:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic evt, input logic [1:0] cur, input logic sec,
                       input logic h2, input logic h3, input logic [3:1] wide,
                       input logic [5:0] ctl);
    req_valid  = 1'b1;
    req_is_evt = evt;  cur_lvl = cur;  sec_state = sec;
    has_lvl2   = h2;   has_lvl3 = h3;  lvl_wide = wide;
    {mon_t_int, mon_t_evt, hyp_t_int, hyp_t_evt, sys_nt_int, sys_nt_evt} = ctl;
  endtask

  // one strobe, compare one cycle later, then an idle cycle check
  task automatic one(input string tag, input logic evt, input logic [1:0] cur,
                     input logic sec, input logic h2, input logic h3,
                     input logic [3:1] wide, input logic [5:0] ctl);
    @(negedge clk);
    drive(evt, cur, sec, h2, h3, wide, ctl);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, observed(), model(evt, cur, sec, h2, h3, wide, ctl));
    @(negedge clk);
    chk("R2 idle after pulse", observed(), 38'd0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 reset state", observed(), 38'd0);
    // strobe while in reset has no effect
    drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 6'b000000);
    @(negedge clk);
    chk("R1 strobe during reset", observed(), 38'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R2 no strobe after reset", observed(), 38'd0);
  endtask

  task automatic test_lvl1();
    one("R3 evt at level 0, 32-bit", 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 6'b111110);
    chk("R8 undefined class", {35'd0, rsp_fault}, 38'd0); // idle cycle fields cleared
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001, 6'b000001);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 int level 1 64-bit explicit", observed(),
        {1'b1, 1'b1, 2'd1, 3'd2, 6'h01, 25'h1E00000});
    one("R3 level 1 bit ignored at cur 1", 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 3'b000, 6'b000000);
  endtask

  task automatic test_lvl2();
    one("R4 hyp trap at level 1", 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 3'b000, 6'b000111);
    one("R4 secure state masks level 2", 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 3'b000, 6'b001111);
    one("R4 absent level 2 masked", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000, 6'b001011);
    one("R9 hyp class ignores width", 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 3'b111, 6'b001011);
  endtask

  task automatic test_lvl3();
    one("R5 mon trap at level 2", 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 3'b000, 6'b011111);
    one("R5 masked at level 3", 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 3'b000, 6'b111111);
    @(negedge clk);
    drive(1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 3'b100, 6'b101011);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 mon class explicit", observed(),
        {1'b1, 1'b1, 2'd3, 3'd4, 6'h01, 25'h1E00000});
  endtask

  task automatic test_priority();
    one("R6 level 1 beats 2 and 3", 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 6'b010100);
    one("R6 level 2 beats 3", 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 6'b101011);
    one("R7 wrong kind bit does not trap", 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 3'b000, 6'b101011);
  endtask

  task automatic test_sweep();
    logic [14:0] v;
    for (int i = 0; i < 32768; i++) begin
      v = 15'(i);
      @(negedge clk);
      if (i > 0) chk("R6 sweep", observed(),
                     model(v[0] ^ 1'b0 ? 1'b0 : 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'b0, 6'b0) & 38'd0 | last_exp);
      drive(v[0], v[2:1], v[3], v[4], v[5], v[8:6], v[14:9]);
      last_exp = model(v[0], v[2:1], v[3], v[4], v[5], v[8:6], v[14:9]);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 sweep last", observed(), last_exp);
    @(negedge clk);
    chk("R2 idle after sweep", observed(), 38'd0);
  endtask

  logic [37:0] last_exp = '0;

  initial begin
    test_reset();
    test_lvl1();
    test_lvl2();
    test_lvl3();
    test_priority();
    test_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule